// File: doc/BRIEF.md
# Token-Ring Depth Cascade FIFO

This block builds one deep first-in first-out queue out of several identical storage slices. No shared address counter exists. Each slice keeps its own write and read pointers and two ownership bits: one for writing and one for reading. Only the slice that owns the write token stores an incoming word. Only the slice that owns the read token returns a word. When a slice stores into, or reads from, its highest location, it raises a one-cycle hand-off pulse toward the next slice in a closed ring. That pulse moves only the token it belongs to, and the next slice owns that token from the following clock edge.

A first-load strap, set by a parameter and tied per slice at the top, names the slice that owns both tokens after reset. Every other slice starts with no token. The composite full and empty outputs combine the per-slice active-low flags, so that a flag raised by any slice drives the composite. The data outputs of all slices are merged by OR. A slice that is not reading therefore holds its data output at zero. Repeat-from-start and threshold flags are not offered in this arrangement.

Top module: `fifo_cascade`

## Requirements
- R1: While `rst` is high and after it falls, every slice pointer is at location zero. `empty` is 1 and `full` is 0. `wr_owner` and `rd_owner` both equal the one-hot mask `1 << LEAD` (bit i stands for slice i).
- R2: A write is accepted only by the slice named in `wr_owner`. After SLICE_DEPTH accepted writes in that slice, ownership moves to slice (i+1) mod NSLICE from the next clock edge.
- R3: A read is accepted only by the slice named in `rd_owner`. After SLICE_DEPTH accepted reads in that slice, read ownership moves to slice (i+1) mod NSLICE from the next clock edge.
- R4: Read hand-offs never change `wr_owner`, and write hand-offs never change `rd_owner`. Each owner vector always has exactly one bit set.
- R5: Words come out in the order they were accepted, across slice boundaries and ring wrap-around. `rd_valid` is 1 and `rd_data` holds the word in the cycle after an accepted read.
- R6: `full` is 1 exactly when NSLICE*SLICE_DEPTH words are held. A write strobe while `full` is 1 is ignored: no word is stored and `wr_owner` does not change.
- R7: `empty` is 1 exactly when no word is held. A read strobe while `empty` is 1 is ignored: `rd_valid` stays 0 in the next cycle.
- R8: Every slice not performing a read drives zero on its data output. As a result, `rd_data` is zero whenever `rd_valid` is 0.
- R9: A write and a read in the same cycle are both accepted when their own conditions hold, including when both fall in the same slice. Acceptance uses the flags from before that clock edge.
- R10: `full` and `empty` are active-high composites. Each is the OR of the matching per-slice flag. A slice raises its flag only while it owns the relevant token and its storage is full, or empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Word returned, zero when idle |
| rd_valid | output | 1 | `rd_data` carries a word read in the previous cycle |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| wr_owner | output | NSLICE | One-hot: slice holding the write token |
| rd_owner | output | NSLICE | One-hot: slice holding the read token |

## Verification
The hardest case to reach is the writer re-entering the slice that the reader still occupies after the ring has wrapped. In that case `full` comes from a slice whose write pointer has caught up with its own read pointer partway through the slice, not from a simple fill. The stimulus first fills and drains the whole ring. It then runs long stretches of random, write-biased simultaneous traffic, so the level sits near capacity while both tokens circle the ring several times. A read-biased stretch follows to exercise the matching empty case. A behavioural queue model checks every output on every cycle throughout.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  // Per-slice flags, active low, as combined by the merge stage.
  typedef struct packed {
    logic full_n;
    logic empty_n;
  } slice_flags_t;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/cascade_slice.sv
module cascade_slice
  import cascade_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_ld_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             xi_wr,
  input  logic             xi_rd,
  output logic             xo_wr,
  output logic             xo_rd,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld,
  output slice_flags_t     flags,
  output logic             wtok,
  output logic             rtok
);
  localparam int AW = ptr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             wr_ok, rd_ok, at_full, at_empty;

  assign at_full  = (cnt == CFULL);
  assign at_empty = (cnt == '0);
  assign wr_ok    = wr_en & wtok & ~at_full;
  assign rd_ok    = rd_en & rtok & ~at_empty;
  assign xo_wr    = wr_ok & (wptr == LAST);
  assign xo_rd    = rd_ok & (rptr == LAST);

  assign flags.full_n  = ~(wtok & at_full);
  assign flags.empty_n = ~(rtok & at_empty);

  // Storage: plain write port, no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  // Registered read port; zero when this slice does not read.
  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (rd_ok) dout <= mem[rptr];
    else            dout <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      wtok     <= ~first_ld_n;
      rtok     <= ~first_ld_n;
      dout_vld <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt      <= cnt + CW'(wr_ok) - CW'(rd_ok);
      wtok     <= (wtok & ~xo_wr) | xi_wr;
      rtok     <= (rtok & ~xo_rd) | xi_rd;
      dout_vld <= rd_ok;
    end
  end

  // R8: an idle slice keeps its data output at zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> (dout == '0));
  // R2: an incoming write hand-off gives this slice the write token
  a_r2_token_in: assert property (@(posedge clk) disable iff (rst)
    xi_wr |=> wtok);
  // R3: an incoming read hand-off gives this slice the read token
  a_r3_token_in: assert property (@(posedge clk) disable iff (rst)
    xi_rd |=> rtok);
  // R6: occupancy never exceeds the slice size
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CFULL);
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge
  import cascade_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int NSLICE = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  slice_flags_t [NSLICE-1:0] flags,
  input  logic [NSLICE*WIDTH-1:0]   dout_all,
  input  logic [NSLICE-1:0]         vld_all,
  output logic [WIDTH-1:0]          rd_data,
  output logic                      rd_valid,
  output logic                      full,
  output logic                      empty
);
  always_comb begin
    rd_data = '0;
    full    = 1'b0;
    empty   = 1'b0;
    for (int i = 0; i < NSLICE; i++) begin
      rd_data = rd_data | dout_all[i*WIDTH +: WIDTH];
      full    = full  | ~flags[i].full_n;
      empty   = empty | ~flags[i].empty_n;
    end
  end
  assign rd_valid = |vld_all;

  // R8: at most one slice returns a word in any cycle
  a_r8_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vld_all));
  // R10: the composite can never be full and empty at once
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/fifo_cascade.sv
module fifo_cascade
  import cascade_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int SLICE_DEPTH = 8,
  parameter int NSLICE      = 3,
  parameter int LEAD        = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty,
  output logic [NSLICE-1:0] wr_owner,
  output logic [NSLICE-1:0] rd_owner
);
  localparam logic [NSLICE-1:0] LEAD_MASK = NSLICE'(1) << LEAD;

  logic [NSLICE-1:0]         xo_wr, xo_rd, vld_all;
  logic [NSLICE*WIDTH-1:0]   dout_all;
  slice_flags_t [NSLICE-1:0] flags;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int PREV = (i + NSLICE - 1) % NSLICE;
    cascade_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .first_ld_n ((i == LEAD) ? 1'b0 : 1'b1),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .xi_wr      (xo_wr[PREV]),
      .xi_rd      (xo_rd[PREV]),
      .xo_wr      (xo_wr[i]),
      .xo_rd      (xo_rd[i]),
      .dout       (dout_all[i*WIDTH +: WIDTH]),
      .dout_vld   (vld_all[i]),
      .flags      (flags[i]),
      .wtok       (wr_owner[i]),
      .rtok       (rd_owner[i])
    );
  end

  cascade_merge #(.WIDTH(WIDTH), .NSLICE(NSLICE)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .flags    (flags),
    .dout_all (dout_all),
    .vld_all  (vld_all),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty)
  );

  // R1: the first cycle out of reset shows the strapped lead slice
  a_r1_lead_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_owner == LEAD_MASK && rd_owner == LEAD_MASK && empty && !full));
  // R4: exactly one write owner and one read owner
  a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_owner) == 1 && $countones(rd_owner) == 1);
  // R4: the read token moves only on read strobes
  a_r4_read_token_still: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_owner));
  // R6: a write against a full ring does not move the write token
  a_r6_blocked_write: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wr_owner));
  // R7: a read against an empty ring returns nothing
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    empty |=> !rd_valid);
endmodule

// File: tb/tb_fifo_cascade.sv
module tb_fifo_cascade;
  localparam int W    = 9;
  localparam int D    = 8;
  localparam int N    = 3;
  localparam int LEAD = 0;
  localparam int CAP  = N * D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty;
  logic [N-1:0] wr_owner, rd_owner;

  int errors = 0, checks = 0;
  bit done = 0;
  string ph = "R1";

  always #4 clk = ~clk;

  fifo_cascade #(.WIDTH(W), .SLICE_DEPTH(D), .NSLICE(N), .LEAD(LEAD)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
    .wr_owner(wr_owner), .rd_owner(rd_owner));

  // Behavioural reference: a queue plus running totals.
  logic [W-1:0] q[$];
  int wcount = 0, rcount = 0;
  logic         exp_valid = 0;
  logic [W-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); wcount = 0; rcount = 0; exp_valid = 0; exp_data = '0;
    end else begin
      bit wa, ra;
      wa = wr_en && (q.size() < CAP);
      ra = rd_en && (q.size() > 0);
      exp_valid = ra;
      exp_data  = ra ? q[0] : '0;
      if (ra) begin void'(q.pop_front()); rcount++; end
      if (wa) begin q.push_back(wr_data); wcount++; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [N-1:0] ew, er;
      ew = N'(1) << ((LEAD + wcount / D) % N);
      er = N'(1) << ((LEAD + rcount / D) % N);
      check({ph, " R5 rd_valid"}, 32'(rd_valid), 32'(exp_valid));
      check({ph, exp_valid ? " R5 rd_data" : " R8 idle rd_data"}, 32'(rd_data), 32'(exp_data));
      check({ph, " R6 R10 full"}, 32'(full), 32'(q.size() == CAP));
      check({ph, " R7 R10 empty"}, 32'(empty), 32'(q.size() == 0));
      check({ph, " R2 R4 wr_owner"}, 32'(wr_owner), 32'(ew));
      check({ph, " R3 R4 rd_owner"}, 32'(rd_owner), 32'(er));
    end
  end

  task automatic drive(input logic w, input logic [W-1:0] d, input logic r);
    @(posedge clk); #1;
    wr_en = w; wr_data = d; rd_en = r;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset empty", 32'(empty), 32'd1);
    check("R1 reset full", 32'(full), 32'd0);
    check("R1 reset wr_owner", 32'(wr_owner), 32'(N'(1) << LEAD));
    check("R1 reset rd_owner", 32'(rd_owner), 32'(N'(1) << LEAD));
    @(posedge clk); #1 rst = 1'b0;

    ph = "R2 fill";
    for (int i = 0; i < CAP; i++) drive(1'b1, W'(i * 37 + 5), 1'b0);
    ph = "R6 overfull";
    for (int i = 0; i < 4; i++) drive(1'b1, W'(9'h1F0 + i), 1'b0);
    ph = "R3 R4 drain";
    for (int i = 0; i < CAP; i++) drive(1'b0, '0, 1'b1);
    ph = "R7 underflow";
    for (int i = 0; i < 4; i++) drive(1'b0, '0, 1'b1);
    ph = "R9 write-heavy";
    for (int i = 0; i < 600; i++) begin
      lfsr = step(lfsr);
      drive(lfsr[1:0] != 2'b00, W'(lfsr[12:4]), lfsr[2]);
    end
    ph = "R9 read-heavy";
    for (int i = 0; i < 600; i++) begin
      lfsr = step(lfsr);
      drive(lfsr[2], W'(lfsr[13:5]), lfsr[1:0] != 2'b00);
    end
    ph = "R9 full simultaneous";
    while (q.size() < CAP) drive(1'b1, W'(q.size() + 3), 1'b0);
    for (int i = 0; i < 10; i++) drive(1'b1, W'(i + 9'h40), 1'b1);
    ph = "R5 final drain";
    for (int i = 0; i < CAP + 2; i++) drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule